// File: doc/BRIEF.md
# Stereo Subcarrier Switching Sequencer

This block produces all the digital timing for a stepped-switch stereo encoder. A fast master clock is divided into a step clock. The step clock moves a single token around a ring of 14 stages. The ring stages are combined into one enable line per tap of an analog resistor chain that runs between the left and right signals. A full sweep of the ring walks the tap from the centre to one end, back across to the other end, and partway home again. One such sweep makes one subcarrier period. The result is a soft, staircase-shaped change between the two channels rather than a hard switch.

From the same ring the block derives a pilot square wave at half the sweep rate, and a gate can silence it. The pilot has two phase options. The fixed option is taken directly from one ring stage. The shifted option takes an earlier stage and delays it by a programmable number of master-clock cycles. The block also emits a sample-and-hold strobe that lags each step by a fixed number of master cycles. The ring starts itself from reset and cannot carry two tokens at once.

Top module: `stereo_step_seq`

## Requirements
- R1: The tap enables advance exactly once every DIV (default 8) master-clock cycles.
- R2: During reset and until the first step, `sw_en`, `pilot_sq` and `sh_strobe` are all 0. The first step after reset lights tap 3.
- R3: Once running, exactly one bit of `sw_en` is high, with bit i meaning chain tap i.
- R4: Successive steps light taps 3,2,1,0,1,2,3,4,5,6,7,6,5,4, and this 14-step sweep repeats without end.
- R5: With `pilot_mode`=0 (fixed), the pilot state inverts in the same cycle in which the 8th step of each sweep (the first visit to tap 4) appears. The result is a square wave with a period of 224 master cycles and a high time of 112.
- R6: With `pilot_mode`=1 (shifted), the pilot state inverts exactly `phase_dly` master cycles after the 6th step of each sweep (the second visit to tap 2) appears.
- R7: In shifted mode, a `phase_dly` of 0 acts as a delay of 1 cycle.
- R8: While `pilot_en` is 0, `pilot_sq` is 0. The pilot divider keeps running, so re-enabling restores the same phase it would have had.
- R9: `sh_strobe` is a one-cycle pulse exactly SH_LAG (default 3) master cycles after each step appears, and is low at every other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock (nominal 4.256 MHz) |
| rst_n | input | 1 | Active-low synchronous reset |
| pilot_mode | input | 1 | Static pilot phase select: 0 fixed, 1 shifted |
| pilot_en | input | 1 | Pilot output gate, 1 = pilot on |
| phase_dly | input | DLY_W | Shifted-mode delay in master cycles |
| sw_en | output | NPOS | One enable per resistor-chain tap |
| pilot_sq | output | 1 | Pilot square wave |
| sh_strobe | output | 1 | Delayed per-step sample strobe |

## Verification
The ring's self-correction against stray or duplicated tokens cannot be reached from the ports, because reset leaves the ring empty and nothing at the edge can corrupt it. The stimulus therefore reaches the empty-ring start-up path by sampling straight after every reset. An in-module one-hot assertion covers the cleared-stage logic over every later step. The shifted pilot phase needs its toggle placed against the correct one of the two visits to tap 2. The bench runs several delays, including zero and the maximum, and tracks each step index from reset so that it knows which visit is which.

// File: rtl/stss_pkg.sv
package stss_pkg;

   typedef enum logic {
      PILOT_FIXED   = 1'b0,
      PILOT_SHIFTED = 1'b1
   } pilot_mode_e;

   // Tap selected by ring stage 'stage' (0-based) for a chain of 'npos' taps:
   // a triangle walk that starts just below the centre and heads to tap 0 first.
   function automatic int chain_pos(int stage, int npos);
      int ns;
      int start;
      int j;
      ns    = 2 * (npos - 1);
      start = npos / 2 - 1;
      j     = (stage + ns - start) % ns;
      return (j <= npos - 1) ? j : ns - j;
   endfunction

endpackage

// File: rtl/stss_step_div.sv
module stss_step_div #(
   parameter int DIV = 8
) (
   input  logic clk,
   input  logic rst_n,
   output logic step_tick
);
   localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)                    cnt <= '0;
      else if (cnt == CW'(DIV - 1))  cnt <= '0;
      else                           cnt <= cnt + CW'(1);
   end

   assign step_tick = (cnt == CW'(DIV - 1));

   // R1: a step pulse never lasts two master cycles
   a_r1_tick_gap : assert property (@(posedge clk) disable iff (!rst_n)
      step_tick |=> !step_tick);

endmodule

// File: rtl/stss_token_ring.sv
module stss_token_ring #(
   parameter int NS = 14
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          step_tick,
   output logic [NS-1:0] ring
);
   // stages kept when the token sits one before the last stage
   localparam logic [NS-1:0] KEEP = {1'b1, {(NS-2){1'b0}}, 1'b1};

   logic [NS-1:0] rotated;
   logic [NS-1:0] ring_nxt;

   assign rotated = {ring[NS-2:0], ring[NS-1]};

   always_comb begin
      if (ring == '0)          ring_nxt = {{(NS-1){1'b0}}, 1'b1};
      else if (ring[NS-2])     ring_nxt = rotated & KEEP;
      else                     ring_nxt = rotated;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)          ring <= '0;
      else if (step_tick)  ring <= ring_nxt;
   end

   // R3: never more than one token
   a_r3_single_token : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ring));

   // R2: an empty ring is seeded into stage 1 on the next step
   a_r2_self_start : assert property (@(posedge clk) disable iff (!rst_n)
      (step_tick && ring == '0) |=> ring[0] && $onehot(ring));

   // R4: the last stage wraps to the first
   a_r4_wrap : assert property (@(posedge clk) disable iff (!rst_n)
      (step_tick && ring[NS-1]) |=> ring[0]);

   // R3: a running ring never empties
   a_r3_stays_live : assert property (@(posedge clk) disable iff (!rst_n)
      (ring != '0) |=> (ring != '0));

endmodule

// File: rtl/stss_switch_map.sv
module stss_switch_map #(
   parameter int NPOS = 8,
   parameter int NS   = 2 * (NPOS - 1)
) (
   input  logic [NS-1:0]   ring,
   output logic [NPOS-1:0] sw_en
);
   function automatic logic [NS-1:0] stage_mask(int p);
      logic [NS-1:0] m;
      m = '0;
      for (int s = 0; s < NS; s++)
         if (stss_pkg::chain_pos(s, NPOS) == p) m[s] = 1'b1;
      return m;
   endfunction

   for (genvar p = 0; p < NPOS; p++) begin : g_tap
      localparam logic [NS-1:0] MASK = stage_mask(p);
      assign sw_en[p] = |(ring & MASK);
   end

endmodule

// File: rtl/stss_pilot_gen.sv
module stss_pilot_gen #(
   parameter int DLY_W = 5
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  step_tick,
   input  logic                  fix_hot,
   input  logic                  shf_hot,
   input  stss_pkg::pilot_mode_e mode,
   input  logic                  pilot_en,
   input  logic [DLY_W-1:0]      phase_dly,
   output logic                  pilot_sq
);
   import stss_pkg::*;

   logic             fix_trig;
   logic             shf_trig;
   logic [DLY_W-1:0] oneshot;
   logic             tog;

   assign fix_trig = step_tick & fix_hot;
   assign shf_trig = step_tick & shf_hot;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         oneshot <= '0;
         tog     <= 1'b0;
      end else if (mode == PILOT_FIXED) begin
         oneshot <= '0;
         if (fix_trig) tog <= ~tog;
      end else begin
         if (shf_trig)
            oneshot <= (phase_dly == '0) ? DLY_W'(1) : phase_dly;
         else if (oneshot != '0)
            oneshot <= oneshot - DLY_W'(1);
         if (oneshot == DLY_W'(1)) tog <= ~tog;
      end
   end

   assign pilot_sq = pilot_en & tog;

   // R5: fixed mode inverts on its trigger step
   a_r5_fixed_flip : assert property (@(posedge clk) disable iff (!rst_n)
      (mode == PILOT_FIXED && fix_trig) |=> (tog != $past(tog)));

   // R5: fixed mode holds between triggers
   a_r5_fixed_hold : assert property (@(posedge clk) disable iff (!rst_n)
      (mode == PILOT_FIXED && !fix_trig) |=> (tog == $past(tog)));

   // R7: shifted mode never inverts on the trigger edge itself
   a_r7_min_delay : assert property (@(posedge clk) disable iff (!rst_n)
      (mode == PILOT_SHIFTED && shf_trig && oneshot == '0) |=> (tog == $past(tog)));

endmodule

// File: rtl/stss_strobe_gen.sv
module stss_strobe_gen #(
   parameter int SH_LAG = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic step_tick,
   output logic sh_strobe
);
   logic [SH_LAG:0] pipe;

   always_ff @(posedge clk) begin
      if (!rst_n) pipe <= '0;
      else        pipe <= {pipe[SH_LAG-1:0], step_tick};
   end

   assign sh_strobe = pipe[SH_LAG];

   // R9: at most one step in flight through the delay line
   a_r9_one_in_flight : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(pipe));

endmodule

// File: rtl/stereo_step_seq.sv
module stereo_step_seq #(
   parameter int DIV         = 8,
   parameter int NPOS        = 8,
   parameter int DLY_W       = 5,
   parameter int SH_LAG      = 3,
   parameter int FIX_STAGE   = 8,
   parameter int SHIFT_STAGE = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pilot_mode,
   input  logic             pilot_en,
   input  logic [DLY_W-1:0] phase_dly,
   output logic [NPOS-1:0]  sw_en,
   output logic             pilot_sq,
   output logic             sh_strobe
);
   import stss_pkg::*;

   localparam int NS = 2 * (NPOS - 1);

   if (DIV < 2) begin : g_bad_div
      $error("DIV must be at least 2");
   end
   if (NPOS < 3) begin : g_bad_npos
      $error("NPOS must be at least 3");
   end
   if (SH_LAG < 1 || SH_LAG >= DIV) begin : g_bad_lag
      $error("SH_LAG must lie in 1..DIV-1");
   end
   if (FIX_STAGE < 2 || FIX_STAGE > NS || SHIFT_STAGE < 2 || SHIFT_STAGE > NS) begin : g_bad_stage
      $error("pilot stages must lie in 2..NS");
   end

   logic          step_tick;
   logic [NS-1:0] ring;

   stss_step_div #(.DIV(DIV)) u_div (
      .clk(clk), .rst_n(rst_n), .step_tick(step_tick)
   );

   stss_token_ring #(.NS(NS)) u_ring (
      .clk(clk), .rst_n(rst_n), .step_tick(step_tick), .ring(ring)
   );

   stss_switch_map #(.NPOS(NPOS), .NS(NS)) u_map (
      .ring(ring), .sw_en(sw_en)
   );

   // trigger one step ahead so the toggle lands with the chosen stage
   stss_pilot_gen #(.DLY_W(DLY_W)) u_pilot (
      .clk(clk), .rst_n(rst_n), .step_tick(step_tick),
      .fix_hot(ring[FIX_STAGE-2]), .shf_hot(ring[SHIFT_STAGE-2]),
      .mode(pilot_mode_e'(pilot_mode)), .pilot_en(pilot_en),
      .phase_dly(phase_dly), .pilot_sq(pilot_sq)
   );

   stss_strobe_gen #(.SH_LAG(SH_LAG)) u_strobe (
      .clk(clk), .rst_n(rst_n), .step_tick(step_tick), .sh_strobe(sh_strobe)
   );

   // R3: tap enables never overlap
   a_r3_tap_onehot : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sw_en));

   // R8: a gated pilot stays low
   a_r8_gate_low : assert property (@(posedge clk) disable iff (!rst_n)
      !pilot_en |-> !pilot_sq);

endmodule

// File: tb/test_stereo_step_seq.sv
module test_stereo_step_seq;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pilot_mode = 1'b0;
   logic       pilot_en = 1'b1;
   logic [4:0] phase_dly = 5'd0;
   logic [7:0] sw_en;
   logic       pilot_sq;
   logic       sh_strobe;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   int SEQ[14] = '{3, 2, 1, 0, 1, 2, 3, 4, 5, 6, 7, 6, 5, 4};

   always #4 clk = ~clk;

   stereo_step_seq i_stereo_step_seq (
      .clk(clk), .rst_n(rst_n), .pilot_mode(pilot_mode), .pilot_en(pilot_en),
      .phase_dly(phase_dly), .sw_en(sw_en), .pilot_sq(pilot_sq), .sh_strobe(sh_strobe)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // One scenario: reset, then run ncyc cycles against a model of R1..R9.
   task automatic run_case(input logic mode, input logic [4:0] dly,
                           input int off_at, input int on_at, input int ncyc,
                           input string ptag);
      int cyc = 0;
      int s = 0;
      int last = -100;
      int pend = -1;
      int deff;
      logic [7:0] prev = '0;
      logic etog = 1'b0;
      logic en_now = 1'b1;
      int e1 = 0, e3 = 0, e4 = 0, ep = 0, e8 = 0, e9 = 0;
      deff = (dly == 0) ? 1 : int'(dly);
      rst_n = 1'b0; pilot_mode = mode; phase_dly = dly; pilot_en = 1'b1;
      repeat (4) @(posedge clk);
      @(negedge clk);
      // R2: outputs quiet in reset
      check(sw_en == 0 && pilot_sq == 0 && sh_strobe == 0, "R2 reset state",
            int'({sw_en, pilot_sq, sh_strobe}), 0);
      rst_n = 1'b1;
      for (int i = 0; i < ncyc; i++) begin
         @(negedge clk);
         cyc++;
         if (sw_en != prev) begin
            if (s > 0 && cyc - last != 8) e1++;
            if (!$onehot(sw_en)) e3++;
            else if (sw_en != (8'b1 << SEQ[s % 14])) e4++;
            if (s == 0) check(sw_en == 8'b0000_1000, "R2 first tap", int'(sw_en), 8);
            if (mode == 1'b0 && s % 14 == 7) etog = ~etog;
            if (mode == 1'b1 && s % 14 == 5) pend = cyc + deff;
            last = cyc; prev = sw_en; s++;
         end
         if (cyc == pend) begin etog = ~etog; pend = -1; end
         if (sh_strobe !== (cyc == last + 3)) e9++;
         if (pilot_sq !== (en_now & etog)) begin
            if (!en_now) e8++; else ep++;
         end
         if (i == off_at) begin pilot_en = 1'b0; en_now = 1'b0; end
         if (i == on_at)  begin pilot_en = 1'b1; en_now = 1'b1; end
      end
      check(e1 == 0 && s >= ncyc / 8 - 1, "R1 step period", e1, 0);
      check(e3 == 0, "R3 single tap", e3, 0);
      check(e4 == 0, "R4 sweep order", e4, 0);
      check(e9 == 0, "R9 strobe lag", e9, 0);
      check(ep == 0, ptag, ep, 0);
      if (off_at >= 0) check(e8 == 0, "R8 gated pilot", e8, 0);
   endtask

   task automatic t_fixed;    run_case(1'b0, 5'd0,  -1, -1, 1200, "R5 fixed pilot");   endtask
   task automatic t_shift10;  run_case(1'b1, 5'd10, -1, -1, 1200, "R6 shifted pilot"); endtask
   task automatic t_shift31;  run_case(1'b1, 5'd31, -1, -1, 1200, "R6 shifted max");   endtask
   task automatic t_shift0;   run_case(1'b1, 5'd0,  -1, -1, 1200, "R7 zero delay");    endtask
   task automatic t_gate;     run_case(1'b0, 5'd0, 300, 650, 1400, "R8 pilot resume"); endtask
   task automatic t_gate_shf; run_case(1'b1, 5'd7, 100, 900, 1400, "R8 shifted resume"); endtask

   initial begin
      t_fixed();
      t_shift10();
      t_shift31();
      t_shift0();
      t_gate();
      t_gate_shf();
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         done = 1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual 1 expected 0");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule